// File: doc/BRIEF.md
# Real-Time-Clock Register Space with Staged Transfers

This block is the byte-addressed register space of a real-time clock. A host reaches it through one synchronous port: an address, a write byte, a write strobe and a combinational read byte. The space holds three status/control bytes, a trimming byte, nine time/date staging bytes, five alarm bytes, four timer staging bytes and sixteen bytes of general-purpose RAM. Behind the staging bytes there is a hidden clock area of nine bytes and a hidden timer area of four bytes. The host can never address these hidden areas.

The host moves data between staging and hidden storage with two writes. The first write goes to a command address and arms a transfer. The very next write strobe performs that transfer, whatever its address, and its own data is thrown away. An initialisation sequence resets the status bytes: a write that sets bit 4 of address 0x02, followed by a write that clears it. Byte 0 of the hidden clock counts seconds on a tick input. It counts only while the frequency-tuning mode bit is clear.

A standby input cuts the host off from the block. The RAM keeps its contents and the ticks keep counting.

Top module: `rtc_regfile`

## Requirements
- R1: After reset, every readable location reads 0x00.
- R2: Locations that read back what was written: status bytes at 0x00 to 0x02, trim at 0x10, time staging at 0x20 to 0x28, alarm at 0x30 to 0x34, timer staging at 0x40 to 0x43, and user RAM at 0x50 to 0x5F.
- R3: Any other address reads 0x00, including the command block 0x60 to 0x6F. No address reaches the hidden areas.
- R4: A write to 0x60 arms the clock load. The next write strobe copies time staging into the hidden clock, and that strobe's own data is discarded.
- R5: A write to 0x61 arms the clock snapshot. The next write strobe copies the hidden clock into time staging.
- R6: Writes to 0x62 and 0x63 do the same as R4 and R5, but for timer staging and the hidden timer.
- R7: Write 0x02 with bit 4 set, then write 0x02 with bit 4 clear. Afterwards 0x00 reads 0x01 (the tuning bit), and 0x01 and 0x02 read 0x00.
- R8: The tuning-mode bit is 0x00 bit 0. Once set, a host write cannot clear it until the trim byte (0x10) has been written since the last initialisation.
- R9: While the tuning-mode bit is clear, each tick moves hidden-clock byte 0 forward by one, wrapping from 59 to 0. While the bit is set, ticks leave it unchanged.
- R10: The lock bit is 0x01 bit 0. While it is set, an armed clock load is consumed without changing the hidden clock. User RAM writes and the other commands are unaffected.
- R11: While standby is high, writes have no effect and reads return 0x00. User RAM keeps its contents and ticks still count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| standby_i | input | 1 | Standby: host access blocked |
| tick_i | input | 1 | One-second pulse |
| rdata_o | output | 8 | Read data for addr_i |

## Verification
The bench targets the write that follows a command. In a design that let that write land, address 0x50 would change, or the staging byte would be overwritten while the lock bit is set. The bench drives seconds through 58, 59 and back to 0. A design with an off-by-one wrap would snapshot 60. It also clears the tuning bit both before and after the trim write, which catches a design that drops the interlock or keeps it forever. It writes RAM during standby and reads it back afterwards, which exposes a design that lets standby writes land or loses retention.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned TIME_N  = 9;
  localparam int unsigned ALM_N   = 5;
  localparam int unsigned TMR_N   = 4;
  localparam int unsigned URAM_N  = 16;
  localparam int unsigned STAT_N  = 3;

  localparam logic [7:0] STAT_BASE = 8'h00;
  localparam logic [7:0] INIT_ADDR = 8'h02;
  localparam logic [7:0] TRIM_ADDR = 8'h10;
  localparam logic [7:0] TIME_BASE = 8'h20;
  localparam logic [7:0] ALM_BASE  = 8'h30;
  localparam logic [7:0] TMR_BASE  = 8'h40;
  localparam logic [7:0] URAM_BASE = 8'h50;
  localparam logic [7:0] CMD_WCLK_A = 8'h60;
  localparam logic [7:0] CMD_RCLK_A = 8'h61;
  localparam logic [7:0] CMD_WTMR_A = 8'h62;
  localparam logic [7:0] CMD_RTMR_A = 8'h63;

  localparam int unsigned INIT_BIT = 4;
  localparam int unsigned FTM_BIT  = 0;
  localparam int unsigned LOCK_BIT = 0;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WCLK, CMD_RCLK, CMD_WTMR, CMD_RTMR
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic [7:0] a);
    case (a)
      CMD_WCLK_A: return CMD_WCLK;
      CMD_RCLK_A: return CMD_RCLK;
      CMD_WTMR_A: return CMD_WTMR;
      CMD_RTMR_A: return CMD_RTMR;
      default:    return CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rtc_byte_bank.sv
module rtc_byte_bank #(
  parameter int unsigned N    = 4,
  parameter logic [7:0]  BASE = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              load_i,
  input  logic [N-1:0][7:0] load_data_i,
  output logic              hit_o,
  output logic [7:0]        rdata_o,
  output logic [N-1:0][7:0] data_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0][7:0] mem_q;
  logic [7:0]        off;
  logic [IW-1:0]     idx;

  assign off   = addr_i - BASE;
  assign idx   = off[IW-1:0];
  assign hit_o = (32'(off) < N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              mem_q <= '0;
    else if (load_i)          mem_q <= load_data_i;
    else if (we_i && hit_o)   mem_q[idx] <= wdata_i;
  end

  assign rdata_o = hit_o ? mem_q[idx] : 8'h00;
  assign data_o  = mem_q;
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic       ftm_o,
  output logic       lock_o,
  output logic       hit_o,
  output logic [7:0] rdata_o
);
  logic [STAT_N-1:0][7:0] stat_q;
  logic [7:0]             trim_q;
  logic                   trim_done_q;
  logic                   init_fall;

  // init fires on a 1 -> 0 write of the init bit
  assign init_fall = we_i && (addr_i == INIT_ADDR) && stat_q[2][INIT_BIT] && !wdata_i[INIT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q      <= '0;
      trim_q      <= '0;
      trim_done_q <= 1'b0;
    end else if (init_fall) begin
      stat_q      <= {8'h00, 8'h00, 8'h01};
      trim_done_q <= 1'b0;
    end else if (we_i) begin
      if (addr_i == STAT_BASE) begin
        stat_q[0] <= wdata_i;
        // tuning bit sticks until trim has been written
        if (stat_q[0][FTM_BIT] && !trim_done_q) stat_q[0][FTM_BIT] <= 1'b1;
      end
      if (addr_i == STAT_BASE + 8'd1) stat_q[1] <= wdata_i;
      if (addr_i == INIT_ADDR)        stat_q[2] <= wdata_i;
      if (addr_i == TRIM_ADDR) begin
        trim_q      <= wdata_i;
        trim_done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    hit_o   = 1'b1;
    rdata_o = 8'h00;
    if (32'(addr_i - STAT_BASE) < STAT_N) rdata_o = stat_q[addr_i[1:0]];
    else if (addr_i == TRIM_ADDR)         rdata_o = trim_q;
    else                                  hit_o   = 1'b0;
  end

  assign ftm_o  = stat_q[0][FTM_BIT];
  assign lock_o = stat_q[1][LOCK_BIT];

  // R7
  init_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_fall |=> (stat_q == {8'h00, 8'h00, 8'h01}));
  // R8
  ftm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ftm_o && !trim_done_q) |=> ftm_o);
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
  import rtc_regs_pkg::*;
#(
  parameter int unsigned SEC_MOD = 60
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [7:0]             addr_i,
  input  logic                   tick_i,
  input  logic                   ftm_i,
  input  logic                   lock_i,
  input  logic [TIME_N-1:0][7:0] time_stage_i,
  input  logic [TMR_N-1:0][7:0]  tmr_stage_i,
  output logic                   consume_o,
  output logic                   time_load_o,
  output logic                   tmr_load_o,
  output logic [TIME_N-1:0][7:0] clk_o,
  output logic [TMR_N-1:0][7:0]  tmr_o
);
  localparam logic [7:0] SEC_TOP = 8'(SEC_MOD - 1);

  cmd_e                   armed_q;
  logic [TIME_N-1:0][7:0] clk_q;
  logic [TMR_N-1:0][7:0]  tmr_q;
  logic                   exec, wclk_go, wclk_blk, sec_adv;

  assign exec     = we_i && (armed_q != CMD_NONE);
  assign wclk_go  = exec && (armed_q == CMD_WCLK) && !lock_i;
  assign wclk_blk = exec && (armed_q == CMD_WCLK) && lock_i;
  assign sec_adv  = tick_i && !ftm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= CMD_NONE;
    else if (we_i) armed_q <= exec ? CMD_NONE : decode_cmd(addr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      clk_q <= '0;
    else if (wclk_go) clk_q <= time_stage_i;
    else if (sec_adv) clk_q[0] <= (clk_q[0] >= SEC_TOP) ? 8'h00 : clk_q[0] + 8'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                tmr_q <= '0;
    else if (exec && armed_q == CMD_WTMR)       tmr_q <= tmr_stage_i;
  end

  assign consume_o   = exec;
  assign time_load_o = exec && (armed_q == CMD_RCLK);
  assign tmr_load_o  = exec && (armed_q == CMD_RTMR);
  assign clk_o       = clk_q;
  assign tmr_o       = tmr_q;

  // R4
  wclk_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wclk_go |=> (clk_q == $past(time_stage_i)));
  // R9
  sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_adv && !wclk_go && clk_q[0] == SEC_TOP) |=> (clk_q[0] == 8'h00));
  // R10
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wclk_blk && !sec_adv) |=> $stable(clk_q));
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regs_pkg::*;
#(
  parameter int unsigned SEC_MOD = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       standby_i,
  input  logic       tick_i,
  output logic [7:0] rdata_o
);
  logic wr_en, reg_we, consume, time_load, tmr_load, ftm, lock;
  logic ctl_hit, time_hit, alm_hit, tmr_hit, uram_hit;
  logic [7:0] ctl_rd, time_rd, alm_rd, tmr_rd, uram_rd;
  logic [TIME_N-1:0][7:0] time_stage, hid_clk;
  logic [TMR_N-1:0][7:0]  tmr_stage, hid_tmr;
  logic [ALM_N-1:0][7:0]  alm_q;
  logic [URAM_N-1:0][7:0] uram_q;

  assign wr_en  = wr_i && !standby_i;
  assign reg_we = wr_en && !consume;  // the executing strobe carries no data

  rtc_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i, .wdata_i,
    .ftm_o(ftm), .lock_o(lock), .hit_o(ctl_hit), .rdata_o(ctl_rd)
  );

  rtc_shadow #(.SEC_MOD(SEC_MOD)) u_shadow (
    .clk_i, .rst_ni, .we_i(wr_en), .addr_i, .tick_i, .ftm_i(ftm), .lock_i(lock),
    .time_stage_i(time_stage), .tmr_stage_i(tmr_stage), .consume_o(consume),
    .time_load_o(time_load), .tmr_load_o(tmr_load), .clk_o(hid_clk), .tmr_o(hid_tmr)
  );

  rtc_byte_bank #(.N(TIME_N), .BASE(TIME_BASE)) u_time (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i, .wdata_i, .load_i(time_load),
    .load_data_i(hid_clk), .hit_o(time_hit), .rdata_o(time_rd), .data_o(time_stage)
  );

  rtc_byte_bank #(.N(ALM_N), .BASE(ALM_BASE)) u_alarm (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i, .wdata_i, .load_i(1'b0),
    .load_data_i('0), .hit_o(alm_hit), .rdata_o(alm_rd), .data_o(alm_q)
  );

  rtc_byte_bank #(.N(TMR_N), .BASE(TMR_BASE)) u_timer (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i, .wdata_i, .load_i(tmr_load),
    .load_data_i(hid_tmr), .hit_o(tmr_hit), .rdata_o(tmr_rd), .data_o(tmr_stage)
  );

  rtc_byte_bank #(.N(URAM_N), .BASE(URAM_BASE)) u_uram (
    .clk_i, .rst_ni, .we_i(reg_we), .addr_i, .wdata_i, .load_i(1'b0),
    .load_data_i('0), .hit_o(uram_hit), .rdata_o(uram_rd), .data_o(uram_q)
  );

  // each bank drives zero when not hit
  assign rdata_o = standby_i ? 8'h00 : (ctl_rd | time_rd | alm_rd | tmr_rd | uram_rd);

  // R3
  cmd_space_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[7:4] == 4'h6) |-> (rdata_o == 8'h00 && !(ctl_hit | time_hit | alm_hit | tmr_hit | uram_hit)));
  // R11
  standby_ram_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> $stable(uram_q));
  // R11
  standby_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> ($stable(time_stage) && $stable(alm_q)));
endmodule

// File: tb/rtc_regfile_tb_top.sv
module rtc_regfile_tb_top;
  localparam time CLK_P = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0, wr_i = 1'b0, standby_i = 1'b0, tick_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #(CLK_P / 2) clk_i = ~clk_i;

  rtc_regfile dut_i (.clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .standby_i, .tick_i, .rdata_o);

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i); addr_i = a; #1;
    n_chk++;
    if (rdata_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata_o, exp);
    end
  endtask

  task automatic tick1();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic snap_clock();  // read-clock command then executing strobe
    wr(8'h61, 8'h00); wr(8'h5F, 8'hEE);
  endtask

  task automatic t_reset();
    rd_chk(8'h00, 8'h00, "R1"); rd_chk(8'h02, 8'h00, "R1");
    rd_chk(8'h10, 8'h00, "R1"); rd_chk(8'h20, 8'h00, "R1");
    rd_chk(8'h43, 8'h00, "R1"); rd_chk(8'h5F, 8'h00, "R1");
  endtask

  task automatic t_map();
    for (int i = 0; i < 9; i++)  wr(8'h20 + 8'(i), 8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++)  wr(8'h30 + 8'(i), 8'hB0 + 8'(i));
    for (int i = 0; i < 4; i++)  wr(8'h40 + 8'(i), 8'hC0 + 8'(i));
    for (int i = 0; i < 16; i++) wr(8'h50 + 8'(i), 8'(i * 3 + 1));
    wr(8'h10, 8'h5A); wr(8'h01, 8'h80);
    for (int i = 0; i < 9; i++)  rd_chk(8'h20 + 8'(i), 8'hA0 + 8'(i), "R2");
    for (int i = 0; i < 5; i++)  rd_chk(8'h30 + 8'(i), 8'hB0 + 8'(i), "R2");
    for (int i = 0; i < 4; i++)  rd_chk(8'h40 + 8'(i), 8'hC0 + 8'(i), "R2");
    for (int i = 0; i < 16; i++) rd_chk(8'h50 + 8'(i), 8'(i * 3 + 1), "R2");
    rd_chk(8'h10, 8'h5A, "R2"); rd_chk(8'h01, 8'h80, "R2");
  endtask

  task automatic t_unmapped();
    wr(8'h29, 8'hFF); wr(8'h35, 8'hFF); wr(8'h44, 8'hFF); wr(8'h70, 8'hFF); wr(8'hFF, 8'hFF);
    rd_chk(8'h29, 8'h00, "R3"); rd_chk(8'h35, 8'h00, "R3"); rd_chk(8'h44, 8'h00, "R3");
    rd_chk(8'h70, 8'h00, "R3"); rd_chk(8'hFF, 8'h00, "R3");
    rd_chk(8'h60, 8'h00, "R3"); rd_chk(8'h6F, 8'h00, "R3");
  endtask

  task automatic t_transfer();
    wr(8'h20, 8'h3A);
    wr(8'h60, 8'h00); wr(8'h50, 8'h77);
    rd_chk(8'h50, 8'h01, "R4");         // executing strobe's data dropped
    wr(8'h20, 8'h00); wr(8'h21, 8'h00);
    snap_clock();
    rd_chk(8'h20, 8'h3A, "R5"); rd_chk(8'h21, 8'hA1, "R5"); rd_chk(8'h28, 8'hA8, "R5");
    rd_chk(8'h5F, 8'h2E, "R5");         // 15*3+1, untouched by the strobe
  endtask

  task automatic t_tick();
    tick1(); snap_clock(); rd_chk(8'h20, 8'h3B, "R9");
    tick1(); snap_clock(); rd_chk(8'h20, 8'h00, "R9");
  endtask

  task automatic t_timer();
    wr(8'h40, 8'h11); wr(8'h41, 8'h22); wr(8'h42, 8'h33); wr(8'h43, 8'h44);
    wr(8'h62, 8'h00); wr(8'h30, 8'h99);
    rd_chk(8'h30, 8'hB0, "R6");
    for (int i = 0; i < 4; i++) wr(8'h40 + 8'(i), 8'h00);
    wr(8'h63, 8'h00); wr(8'h31, 8'h99);
    rd_chk(8'h40, 8'h11, "R6"); rd_chk(8'h41, 8'h22, "R6");
    rd_chk(8'h42, 8'h33, "R6"); rd_chk(8'h43, 8'h44, "R6");
  endtask

  task automatic t_lock();
    wr(8'h01, 8'h01); wr(8'h20, 8'h05);
    wr(8'h60, 8'h00); wr(8'h20, 8'h09);
    rd_chk(8'h20, 8'h05, "R10");
    wr(8'h52, 8'h66); rd_chk(8'h52, 8'h66, "R10");
    snap_clock(); rd_chk(8'h20, 8'h00, "R10");
    wr(8'h01, 8'h00);
  endtask

  task automatic t_init();
    wr(8'h00, 8'hF0); wr(8'h01, 8'h0C);
    wr(8'h02, 8'h10); rd_chk(8'h02, 8'h10, "R7");
    wr(8'h02, 8'h00);
    rd_chk(8'h00, 8'h01, "R7"); rd_chk(8'h01, 8'h00, "R7"); rd_chk(8'h02, 8'h00, "R7");
    tick1(); snap_clock(); rd_chk(8'h20, 8'h00, "R9");  // held while tuning
    wr(8'h00, 8'h00); rd_chk(8'h00, 8'h01, "R8");
    wr(8'h10, 8'hD2); wr(8'h00, 8'h00); rd_chk(8'h00, 8'h00, "R8");
  endtask

  task automatic t_standby();
    wr(8'h55, 8'hAB);
    @(negedge clk_i); standby_i = 1'b1;
    rd_chk(8'h55, 8'h00, "R11");
    wr(8'h55, 8'h11); wr(8'h20, 8'h44);
    tick1();
    @(negedge clk_i); standby_i = 1'b0;
    rd_chk(8'h55, 8'hAB, "R11");
    snap_clock(); rd_chk(8'h20, 8'h01, "R11");
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset(); t_map(); t_unmapped(); t_transfer(); t_tick();
    t_timer(); t_lock(); t_init(); t_standby();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule